// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves data between two parallel ports, A and B, in either direction. Each direction has its own storage bank and three active-low controls: a chip enable, a capture enable and a drive enable. Either direction can be made transparent, can hold a captured word, or can drive the far port, and the two directions do not affect each other. Each port has an input bus and a separate output bus with a drive flag. A pad wrapper can join these into true three-state pins.

The storage is built from clocked registers, not from level-sensitive latches. While a direction is open (chip enable low and capture enable low), its output is a combinational path from the input. On every rising clock edge during that time the register also takes the input. When the direction closes, the output switches to the register. The held word is therefore the input value that was present at the last clock edge before the direction closed. A parameter chooses between asynchronous and synchronous reset. Reset clears both banks to zero.

Top module: `latched_xcvr`

## Requirements
- R1: After reset both storage banks hold zero, so a closed direction that is driving presents all-zero data.
- R2: While a direction's chip enable and capture enable are both low and it is driving, its output equals its source port input in the same cycle, with no clock delay.
- R3: While a direction is closed (chip enable high or capture enable high), its driven output shows the word stored at the last rising clock edge at which it was open, and changes on the source input have no effect on that output.
- R4: `b_drv` is 1 exactly when `ab_ce_n` and `ab_oe_n` are both low.
- R5: `a_drv` is 1 exactly when `ba_ce_n` and `ba_oe_n` are both low. The B-to-A direction captures from `b_in` and drives `a_out` with the same rules as R2 and R3.
- R6: When a port's drive flag is 0, that port's output data bus is all zeros.
- R7: The two directions are independent. Both may drive at the same time, and each port then shows its own direction's data with no arbitration.
- R8: Raising the chip enable while the capture enable stays low also closes the direction. The word captured at the last rising edge before the chip enable rose is kept, and it appears once both enables return low and the capture enable stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low reset, clears both banks |
| a_in | input | WIDTH | Data arriving at port A |
| b_in | input | WIDTH | Data arriving at port B |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B capture enable, active low |
| ab_oe_n | input | 1 | B-side drive enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A capture enable, active low |
| ba_oe_n | input | 1 | A-side drive enable, active low |
| b_out | output | WIDTH | Data driven onto port B |
| b_drv | output | 1 | Port B is driven |
| a_out | output | WIDTH | Data driven onto port A |
| a_drv | output | 1 | Port A is driven |

## Verification
The assertions sample at the rising clock edge. They assume that the data and control inputs are synchronous to `clk` and stable around that edge. This is what lets a held output be compared across successive edges. The bench changes every input only on the falling edge and reads the outputs a short time later, so each sample shows a settled, stable input set. It also keeps all chip enables high during reset, so no direction is open while the banks clear.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Number of transfer directions (A->B and B->A)
   localparam int unsigned LANES = 2;

   typedef enum int unsigned {
      LANE_AB = 0,
      LANE_BA = 1
   } lane_id_e;

   // Active-low controls of one direction
   typedef struct packed {
      logic ce_n;   // chip enable
      logic le_n;   // capture enable
      logic oe_n;   // drive enable
   } lane_ctl_t;

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int unsigned WIDTH     = 8,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (ASYNC_RST) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= d;
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   input  lane_ctl_t        ctl,
   output logic [WIDTH-1:0] dout,
   output logic             drv
);

   logic             open_w;
   logic [WIDTH-1:0] held_w;
   logic [WIDTH-1:0] view_w;

   assign open_w = !ctl.ce_n && !ctl.le_n;

   xcvr_store #(
      .WIDTH     (WIDTH),
      .ASYNC_RST (ASYNC_RST)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (open_w),
      .d     (din),
      .q     (held_w)
   );

   // Transparent bypass while open, stored word otherwise
   assign view_w = open_w ? din : held_w;
   assign drv    = !ctl.ce_n && !ctl.oe_n;
   assign dout   = drv ? view_w : '0;

endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             ab_ce_n,
   input  logic             ab_le_n,
   input  logic             ab_oe_n,
   input  logic             ba_ce_n,
   input  logic             ba_le_n,
   input  logic             ba_oe_n,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drv,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drv
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("latched_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] src_w  [LANES];
   logic [WIDTH-1:0] dst_w  [LANES];
   logic             drv_w  [LANES];
   lane_ctl_t        ctl_w  [LANES];

   assign src_w[LANE_AB] = a_in;
   assign src_w[LANE_BA] = b_in;
   assign ctl_w[LANE_AB] = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
   assign ctl_w[LANE_BA] = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};

   generate
      for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
         xcvr_lane #(
            .WIDTH     (WIDTH),
            .ASYNC_RST (ASYNC_RST)
         ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (src_w[gi]),
            .ctl   (ctl_w[gi]),
            .dout  (dst_w[gi]),
            .drv   (drv_w[gi])
         );
      end
   endgenerate

   assign b_out = dst_w[LANE_AB];
   assign b_drv = drv_w[LANE_AB];
   assign a_out = dst_w[LANE_BA];
   assign a_drv = drv_w[LANE_BA];

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic             ab_ce_n,
   input logic             ab_le_n,
   input logic             ab_oe_n,
   input logic             ba_ce_n,
   input logic             ba_le_n,
   input logic             ba_oe_n,
   input logic [WIDTH-1:0] b_out,
   input logic             b_drv,
   input logic [WIDTH-1:0] a_out,
   input logic             a_drv
);

   logic ab_shut, ba_shut;
   assign ab_shut = ab_ce_n || ab_le_n;
   assign ba_shut = ba_ce_n || ba_le_n;

   AST_B_DRIVE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      b_drv == (!ab_ce_n && !ab_oe_n)); // R4
   AST_A_DRIVE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      a_drv == (!ba_ce_n && !ba_oe_n)); // R5
   AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !b_drv |-> (b_out == '0)); // R6
   AST_A_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !a_drv |-> (a_out == '0)); // R6
   AST_AB_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_shut && b_drv) |-> (b_out == a_in)); // R2
   AST_BA_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_shut && a_drv) |-> (a_out == b_in)); // R5
   AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_shut && $past(ab_shut) && b_drv && $past(b_drv)) |-> $stable(b_out)); // R3
   AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_shut && $past(ba_shut) && a_drv && $past(a_drv)) |-> $stable(a_out)); // R3

endmodule

bind latched_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .a_in    (a_in),
   .b_in    (b_in),
   .ab_ce_n (ab_ce_n),
   .ab_le_n (ab_le_n),
   .ab_oe_n (ab_oe_n),
   .ba_ce_n (ba_ce_n),
   .ba_le_n (ba_le_n),
   .ba_oe_n (ba_oe_n),
   .b_out   (b_out),
   .b_drv   (b_drv),
   .a_out   (a_out),
   .a_drv   (a_drv)
);

// File: tb/latched_xcvr_bench.sv
module latched_xcvr_bench;

   localparam int unsigned W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         ab_ce_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
   logic         ba_ce_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
   logic [W-1:0] b_out, a_out;
   logic         b_drv, a_drv;

   int n_run  = 0;
   int n_fail = 0;
   int cyc    = 0;

   logic [W-1:0] mq_ab = '0, mq_ba = '0;

   always #4 clk = ~clk;

   latched_xcvr #(.WIDTH(W)) u_latched_xcvr (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
      .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
      .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
   );

   function automatic logic exp_drv(input logic ce_n, input logic oe_n);
      return !ce_n && !oe_n;
   endfunction

   function automatic logic [W-1:0] exp_data(input logic ce_n, input logic le_n,
                                             input logic oe_n, input logic [W-1:0] din,
                                             input logic [W-1:0] q);
      if (ce_n || oe_n) return '0;
      return (!le_n) ? din : q;
   endfunction

   function automatic string data_req(input logic ce_n, input logic le_n, input logic oe_n);
      if (ce_n || oe_n) return "R6";
      if (!le_n)        return "R2";
      return "R3";
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // ctl bit map: [0] ab_ce_n [1] ab_le_n [2] ab_oe_n [3] ba_ce_n [4] ba_le_n [5] ba_oe_n
   task automatic step(input logic [5:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag);
      @(negedge clk);
      {ba_oe_n, ba_le_n, ba_ce_n, ab_oe_n, ab_le_n, ab_ce_n} = c;
      a_in = a;
      b_in = b;
      #2;
      if (tag != "") begin
         chk(tag, b_out, exp_data(c[0], c[1], c[2], a, mq_ab));
         chk(tag, a_out, exp_data(c[3], c[4], c[5], b, mq_ba));
      end else begin
         chk(data_req(c[0], c[1], c[2]), b_out, exp_data(c[0], c[1], c[2], a, mq_ab));
         chk(data_req(c[3], c[4], c[5]) == "R6" ? "R6" : "R5",
             a_out, exp_data(c[3], c[4], c[5], b, mq_ba));
      end
      chk("R4", W'(b_drv), W'(exp_drv(c[0], c[2])));
      chk("R5", W'(a_drv), W'(exp_drv(c[3], c[5])));
      @(posedge clk);
      if (!c[0] && !c[1]) mq_ab = a;
      if (!c[3] && !c[4]) mq_ba = b;
   endtask

   initial begin
      void'($urandom(32'd91357));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: closed but driving after reset shows zero
      step(6'b010_010, 8'hA5, 8'h5A, "R1");

      // Every control combination with random data
      for (int c = 0; c < 64; c++)
         step(6'(c), 8'($urandom), 8'($urandom), "");

      // R3: capture, close by le, change input, value held
      step(6'b000_000, 8'h3C, 8'hC3, "R7");
      step(6'b010_010, 8'hFF, 8'h00, "R3");
      step(6'b010_010, 8'h11, 8'h22, "R3");

      // R8: close by ce while le stays low, then reopen drive
      step(6'b000_000, 8'h77, 8'h88, "R2");
      step(6'b001_001, 8'h99, 8'h66, "R8");
      step(6'b001_001, 8'h12, 8'h34, "R8");
      step(6'b010_010, 8'hEE, 8'hDD, "R8");

      // R7: one direction open and driving while the other holds
      step(6'b010_000, 8'h5E, 8'hB1, "R7");
      step(6'b000_010, 8'h4D, 8'hC2, "R7");

      // Constrained random
      for (int i = 0; i < 3000; i++)
         step(6'($urandom), 8'($urandom), 8'($urandom), "");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule